// File: doc/BRIEF.md
# Frequency-Error Window and Integral Loop Filter

This block sits at the input of an automatic frequency control loop. Each cycle it receives a signed 17-bit frequency-error estimate with a valid strobe. A 4-bit scale code picks eight consecutive bits of that estimate, which divides it by a power of two. The resulting signed byte drives a second-order loop filter. The filter's integral path accumulates a left-shifted copy of each accepted byte. Its proportional path adds another shifted copy on top of the accumulator to form the frequency correction.

Between bursts the receiver enable is dropped. A hold bit chooses what happens to the integral state at that point. With hold low, the state restarts from zero. With hold high, the state carries over, so the next burst resumes tracking from where the last one ended. Scale codes above the top valid value are reserved: they feed zero into the filter and raise an error flag.

Top module: `afc_window_loop`

## Requirements
- R1: For scale code n in 0..9, the filter input is the two's-complement byte formed by error bits n+7 down to n (code 0 takes bits 7..0, code 9 takes bits 16..9).
- R2: For scale codes 10 to 15, the filter input is zero, and `code_err` is high in the same cycle. For codes 0 to 9, `code_err` is low.
- R3: On each cycle with `err_vld` and `rx_en` both high, the integral accumulator adds the sign-extended filter input shifted left by `k2_shift`.
- R4: On each accepted sample, `corr_out` takes the value of the filter input shifted left by `k1_shift`, plus the updated accumulator, saturated to ACC_W bits. `corr_out` changes on the clock edge that accepts the sample.
- R5: A high-to-low change of `rx_en` while `hold_acc` is low clears both the accumulator and `corr_out` to zero on that edge.
- R6: A high-to-low change of `rx_en` while `hold_acc` is high leaves the accumulator unchanged, so a zero-input sample after re-enable returns the old value.
- R7: Samples presented while `rx_en` is low do not change the accumulator or `corr_out`.
- R8: The accumulator and `corr_out` clamp at the signed limits of ACC_W bits (+8388607 and -8388608 by default) and never wrap.
- R9: After reset, the accumulator and `corr_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_in | input | DISC_W (17) | Signed frequency-error estimate |
| err_vld | input | 1 | Sample strobe for `err_in` |
| scale_code | input | SH_W (4) | Window position n (valid 0..9) |
| hold_acc | input | 1 | High keeps integral state when the receiver is disabled |
| rx_en | input | 1 | Receiver enable |
| k1_shift | input | SH_W (4) | Proportional gain as a left shift |
| k2_shift | input | SH_W (4) | Integral gain as a left shift |
| corr_out | output | ACC_W (24) | Signed frequency correction |
| code_err | output | 1 | Reserved scale code selected |

## Verification
The window is tested with a set of vectors, one per pattern. Each vector places a distinctive byte at a different bit offset, including the lowest and highest codes. Negative and positive bytes at the top of the word show whether the sign is taken from the selected window. Reserved codes are tried with an all-ones input, so any leak of window bits into the filter shows up as a non-zero result.

Separate sequences cover the rest of the behaviour. Repeated samples with unequal gains separate the proportional path from the integral path. Disable cycles with the hold bit low and then high show the two ways the integral state is handled. Long runs of maximum-gain samples in each direction drive the accumulator into both clamps, and a small sample afterwards shows that it did not wrap.

// File: rtl/afc_window_loop.sv
module afc_window_loop #(
  parameter int DISC_W = 17,
  parameter int WIN_W  = 8,
  parameter int SH_W   = 4,
  parameter int ACC_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DISC_W-1:0]        err_in,
  input  logic                     err_vld,
  input  logic [SH_W-1:0]          scale_code,
  input  logic                     hold_acc,
  input  logic                     rx_en,
  input  logic [SH_W-1:0]          k1_shift,
  input  logic [SH_W-1:0]          k2_shift,
  output logic signed [ACC_W-1:0]  corr_out,
  output logic                     code_err
);
  localparam int MAX_CODE = DISC_W - WIN_W;
  localparam int SUM_W    = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] POS_LIM = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_LIM = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [WIN_W-1:0] win;
  logic signed [ACC_W-1:0] acc, acc_nxt, out_nxt;
  logic signed [SUM_W-1:0] win_ext, k1_term, k2_term;
  logic                    rx_en_q;

  function automatic logic signed [ACC_W-1:0] clamp(input logic signed [SUM_W-1:0] s);
    if (s[SUM_W-1] != s[SUM_W-2]) return s[SUM_W-1] ? NEG_LIM : POS_LIM;
    return s[ACC_W-1:0];
  endfunction

  always_comb begin
    win = '0;
    for (int i = 0; i <= MAX_CODE; i++)
      if (scale_code == SH_W'(i)) win = err_in[i +: WIN_W];
  end

  assign code_err = (scale_code > SH_W'(MAX_CODE));
  assign win_ext  = SUM_W'(win);
  assign k1_term  = win_ext <<< k1_shift;
  assign k2_term  = win_ext <<< k2_shift;
  assign acc_nxt  = clamp({acc[ACC_W-1], acc} + k2_term);
  assign out_nxt  = clamp({acc_nxt[ACC_W-1], acc_nxt} + k1_term);

  wire rx_fall = rx_en_q & ~rx_en;
  wire take    = rx_en & err_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      acc      <= '0;
      corr_out <= '0;
    end else begin
      rx_en_q <= rx_en;
      if (rx_fall && !hold_acc) begin
        acc      <= '0;
        corr_out <= '0;
      end else if (take) begin
        acc      <= acc_nxt;
        corr_out <= out_nxt;
      end
    end
  end
endmodule

// File: rtl/afc_window_loop_chk.sv
module afc_window_loop_chk #(
  parameter int SH_W  = 4,
  parameter int ACC_W = 24,
  parameter int MAX_CODE = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    err_vld,
  input logic                    rx_en,
  input logic                    hold_acc,
  input logic [SH_W-1:0]         scale_code,
  input logic                    code_err,
  input logic signed [ACC_W-1:0] acc,
  input logic signed [ACC_W-1:0] corr_out
);
  p_reserved_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (scale_code > SH_W'(MAX_CODE)) |-> code_err);

  p_reserved_no_effect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && err_vld && scale_code > SH_W'(MAX_CODE)) |=> acc == $past(acc));

  p_clear_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_en) && !hold_acc) |=> (acc == '0 && corr_out == '0));

  p_keep_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rx_en) && hold_acc) |=> acc == $past(acc));

  p_idle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !$fell(rx_en)) |=> ($stable(acc) && $stable(corr_out)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc[ACC_W-1] && !(rx_en && err_vld)) |=> (!acc[ACC_W-1] || !$past(rx_en)));
endmodule

bind afc_window_loop afc_window_loop_chk #(.SH_W(SH_W), .ACC_W(ACC_W), .MAX_CODE(DISC_W-WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .rx_en(rx_en), .hold_acc(hold_acc),
  .scale_code(scale_code), .code_err(code_err), .acc(acc), .corr_out(corr_out)
);

// File: tb/tb_afc_window_loop.sv
module tb_afc_window_loop;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [16:0] err_in = '0;
  logic err_vld = 1'b0, hold_acc = 1'b0, rx_en = 1'b0;
  logic [3:0] scale_code = '0, k1_shift = '0, k2_shift = '0;
  logic signed [23:0] corr_out;
  logic code_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  afc_window_loop dut (.clk(clk), .rst_n(rst_n), .err_in(err_in), .err_vld(err_vld),
    .scale_code(scale_code), .hold_acc(hold_acc), .rx_en(rx_en), .k1_shift(k1_shift),
    .k2_shift(k2_shift), .corr_out(corr_out), .code_err(code_err));

  localparam int NV = 8;
  localparam logic [16:0] V_ERR [NV] = '{17'h000A5, 17'h00A50, 17'h1FFFF, 17'h0FE00,
                                         17'h00155, 17'h1FFFF, 17'h1FFFF, 17'h00400};
  localparam logic [3:0]  V_CODE[NV] = '{4'd0, 4'd4, 4'd9, 4'd9, 4'd1, 4'd10, 4'd15, 4'd3};
  localparam int          V_WIN [NV] = '{-91, -91, -1, 127, -86, 0, 0, -128};

  task automatic chk(input string req, input logic signed [23:0] exp);
    checks++;
    if (corr_out !== exp) begin
      errors++;
      $display("FAIL %s corr_out=%0d expected=%0d", req, corr_out, exp);
    end
  endtask

  task automatic chk_err(input string req, input logic exp);
    checks++;
    if (code_err !== exp) begin
      errors++;
      $display("FAIL %s code_err=%0b expected=%0b", req, code_err, exp);
    end
  endtask

  task automatic sample(input logic [16:0] e, input logic [3:0] c);
    @(negedge clk);
    err_in = e; scale_code = c; err_vld = 1'b1;
    @(negedge clk);
    err_vld = 1'b0;
  endtask

  task automatic disable_cycle(input logic hold);
    @(negedge clk);
    hold_acc = hold; rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", 24'sd0);
    chk_err("R2 code0 at reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    rx_en = 1'b1;
    @(negedge clk);

    // R1, R2 window table with unity gains: corr = 2*win from a cleared state
    for (int i = 0; i < NV; i++) begin
      disable_cycle(1'b0);
      sample(V_ERR[i], V_CODE[i]);
      chk($sformatf("R1 window vector %0d", i), 24'(2 * V_WIN[i]));
      chk_err($sformatf("R2 flag vector %0d", i), V_CODE[i] > 4'd9);
    end

    // R3, R4 accumulation with unequal gains, win=3
    disable_cycle(1'b0);
    k1_shift = 4'd1; k2_shift = 4'd2;
    sample(17'd3, 4'd0);
    chk("R3 first integral step", 24'sd18);
    sample(17'd3, 4'd0);
    chk("R4 proportional plus integral", 24'sd30);

    // R7 ignored sample while disabled
    @(negedge clk); hold_acc = 1'b1; rx_en = 1'b0;
    sample(17'd3, 4'd0);
    chk("R7 disabled sample ignored", 24'sd30);
    @(negedge clk); rx_en = 1'b1;
    sample(17'd0, 4'd0);
    chk("R6 hold keeps accumulator", 24'sd24);

    // R5 clear on fall
    @(negedge clk); hold_acc = 1'b0; rx_en = 1'b0;
    @(negedge clk);
    chk("R5 clear on disable", 24'sd0);
    rx_en = 1'b1;
    sample(17'd0, 4'd0);
    chk("R5 accumulator cleared", 24'sd0);

    // R8 positive clamp
    k1_shift = 4'd0; k2_shift = 4'd15;
    for (int i = 0; i < 3; i++) sample(17'h0007F, 4'd0);
    chk("R8 positive clamp", 24'sd8388607);
    for (int i = 0; i < 4; i++) sample(17'h00080, 4'd0);
    chk("R8 negative clamp", -24'sd8388608);
    k2_shift = 4'd0;
    sample(17'd1, 4'd0);
    chk("R8 no wrap after clamp", -24'sd8388606);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule